// File: doc/BRIEF.md
# I2C Target Receive Queue with Event Tags

This block is the receive side of an I2C target interface. A bit-level engine, which sits outside the block, reports what happened on the bus through one-cycle strobes: a data byte arrived, a START was seen, a repeated START was seen, or a STOP was seen. Each received byte is queued with a tag word. The tag records which own address the byte matched, whether it was acknowledged, whether a timeout forced a NAK, and whether it is the first byte of the transfer.

Repeated START and STOP carry no data, but each one still takes a queue slot as a marker entry. Software therefore reads a single ordered stream of bytes and bus conditions. The head entry's data and tag are always visible at the outputs. One read strobe removes the head entry. A service flag stays high while anything is queued. A sticky overflow flag records an entry that was lost because the queue was full, and a sticky write-complete flag records that a STOP was seen.

Top module: `i2c_rx_tagged_fifo`

## Requirements
- R1: A byte strobe queues the byte with tag bit 0 = address-one match, bit 1 = address-two match, bit 2 = acknowledge sent, bit 3 = timeout NAK, each copied from the inputs of that cycle.
- R2: Tag bit 4 is set on the first byte after a START or repeated START and on no later byte. A STOP withdraws it.
- R3: A repeated START queues a marker entry with data 0 and tag 0x20 (bit 5 only).
- R4: A STOP queues a marker entry with data 0 and tag 0x40 (bit 6 only).
- R5: With at most one event strobe per cycle, entries leave in arrival order. The outputs show the oldest entry's data and tag, and one read strobe advances both together.
- R6: `svc_irq` is high exactly while at least one entry is queued.
- R7: An entry offered while the queue holds DEPTH entries is discarded, the head is unchanged, and `ovf` goes high. `ovf` stays high until `ovf_clr`, and a new loss in the same cycle wins. When a read and a new entry meet a full queue in the same cycle, the new entry is accepted.
- R8: A read strobe on an empty queue changes nothing. An empty queue shows data 0 and tag 0.
- R9: A STOP sets `wr_done`. It stays set until `wr_done_clr`, and a STOP in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START condition seen |
| ev_rstart | input | 1 | Repeated START seen |
| ev_stop | input | 1 | STOP seen |
| ev_byte | input | 1 | Data byte received |
| ev_data | input | DATA_W | Received byte |
| ev_hit_a | input | 1 | Byte matched own address one |
| ev_hit_b | input | 1 | Byte matched own address two |
| ev_acked | input | 1 | Acknowledge was driven for the byte |
| ev_tmo_nak | input | 1 | Byte was NAKed because of a timeout |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | DATA_W | Head entry data |
| rd_tag | output | 7 | Head entry tag |
| svc_irq | output | 1 | Queue needs service |
| wr_done | output | 1 | Sticky write-complete flag |
| wr_done_clr | input | 1 | Clear `wr_done` |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clear `ovf` |

## Verification
The bench builds the block with DEPTH = 5 and DATA_W = 8. A depth that is not a power of two selects the pointer variant that compares against the last slot index, so the wrap from slot 4 back to 0 is exercised many times. The small depth also means random traffic reaches the full state often, which covers lost entries, reads and writes that meet a full queue in the same cycle, and flag clears that collide with new events. Marker entries and the first-byte tag therefore show up at every queue fill level.

// File: rtl/i2c_rxq_pkg.sv
package i2c_rxq_pkg;
   // Bit order of this struct is the software-visible tag layout: hit_a is bit 0.
   typedef struct packed {
      logic stop;
      logic rstart;
      logic first;
      logic tmo_nak;
      logic acked;
      logic hit_b;
      logic hit_a;
   } rxq_tag_t;

   localparam int unsigned TAG_W = $bits(rxq_tag_t);
endpackage

// File: rtl/i2c_rxq_tagger.sv
module i2c_rxq_tagger
   import i2c_rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_rstart,
   input  logic              ev_stop,
   input  logic              ev_byte,
   input  logic [DATA_W-1:0] ev_data,
   input  logic              ev_hit_a,
   input  logic              ev_hit_b,
   input  logic              ev_acked,
   input  logic              ev_tmo_nak,
   output logic              push,
   output rxq_tag_t          push_tag,
   output logic [DATA_W-1:0] push_data
);
   logic armed_q;

   // Armed between a (repeated) START and the first byte that follows it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     armed_q <= 1'b0;
      else if (ev_byte || ev_stop)    armed_q <= 1'b0;
      else if (ev_start || ev_rstart) armed_q <= 1'b1;
   end

   always_comb begin
      push_tag  = '0;
      push_data = '0;
      if (ev_byte) begin
         push_tag.hit_a   = ev_hit_a;
         push_tag.hit_b   = ev_hit_b;
         push_tag.acked   = ev_acked;
         push_tag.tmo_nak = ev_tmo_nak;
         push_tag.first   = armed_q;
         push_data        = ev_data;
      end else if (ev_rstart) begin
         push_tag.rstart  = 1'b1;
      end else if (ev_stop) begin
         push_tag.stop    = 1'b1;
      end
   end

   assign push = ev_byte || ev_rstart || ev_stop;

   // R2: once a byte has been tagged, the next byte is untagged unless a START intervenes
   a_r2_first_once: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte ##1 (ev_byte && !ev_start && !ev_rstart) |-> !push_tag.first);

   // R5: the bit engine presents at most one event per cycle
   a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_start, ev_rstart, ev_stop, ev_byte}));
endmodule

// File: rtl/i2c_rxq_store.sv
module i2c_rxq_store #(
   parameter int unsigned ENT_W = 15,
   parameter int unsigned DEPTH = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            push,
   input  logic [ENT_W-1:0]                push_ent,
   input  logic                            pop,
   output logic [ENT_W-1:0]                head_ent,
   output logic [$clog2(DEPTH+1)-1:0]      cnt,
   output logic                            drop
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             empty, full, do_pop, do_push;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign drop    = push && !do_push;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign rd_nxt = rd_ptr + PTR_W'(1);
         assign wr_nxt = wr_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + PTR_W'(1);
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push) wr_ptr <= wr_nxt;
         if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
         else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_ent;
   end

   assign head_ent = empty ? '0 : mem[rd_ptr];
   assign cnt      = cnt_q;

   // R7: occupancy never exceeds the configured depth
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R8: a read on an empty queue leaves it empty
   a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (cnt_q == '0));

   // R5: a lone read on a non-empty queue removes exactly one entry
   a_r5_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && pop && !push) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R7: a discarded entry leaves the head untouched
   a_r7_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !pop) |=> $stable(head_ent));
endmodule

// File: rtl/i2c_rxq_flags.sv
module i2c_rxq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic drop,
   input  logic ovf_clr,
   input  logic ev_stop,
   input  logic done_clr,
   output logic ovf,
   output logic wr_done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf     <= 1'b0;
         wr_done <= 1'b0;
      end else begin
         if (drop)         ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
         if (ev_stop)       wr_done <= 1'b1;
         else if (done_clr) wr_done <= 1'b0;
      end
   end

   // R7: overflow flag is sticky until cleared
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   // R9: a STOP always leaves the write-complete flag set
   a_r9_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> wr_done);
endmodule

// File: rtl/i2c_rx_tagged_fifo.sv
module i2c_rx_tagged_fifo
   import i2c_rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_rstart,
   input  logic              ev_stop,
   input  logic              ev_byte,
   input  logic [DATA_W-1:0] ev_data,
   input  logic              ev_hit_a,
   input  logic              ev_hit_b,
   input  logic              ev_acked,
   input  logic              ev_tmo_nak,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [TAG_W-1:0]  rd_tag,
   output logic              svc_irq,
   output logic              wr_done,
   input  logic              wr_done_clr,
   output logic              ovf,
   input  logic              ovf_clr
);
   localparam int unsigned ENT_W = TAG_W + DATA_W;
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   if (DEPTH < 2) begin : g_chk_depth
      $error("i2c_rx_tagged_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("i2c_rx_tagged_fifo: DATA_W must be at least 1");
   end

   logic              push, drop;
   rxq_tag_t          push_tag;
   logic [DATA_W-1:0] push_data;
   logic [ENT_W-1:0]  head_ent;
   logic [CNT_W-1:0]  cnt;

   i2c_rxq_tagger #(.DATA_W(DATA_W)) i_tagger (
      .clk(clk), .rst_n(rst_n),
      .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .ev_data(ev_data),
      .ev_hit_a(ev_hit_a), .ev_hit_b(ev_hit_b),
      .ev_acked(ev_acked), .ev_tmo_nak(ev_tmo_nak),
      .push(push), .push_tag(push_tag), .push_data(push_data)
   );

   i2c_rxq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) i_store (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_ent({push_tag, push_data}),
      .pop(rd_pop), .head_ent(head_ent), .cnt(cnt), .drop(drop)
   );

   i2c_rxq_flags i_flags (
      .clk(clk), .rst_n(rst_n),
      .drop(drop), .ovf_clr(ovf_clr),
      .ev_stop(ev_stop), .done_clr(wr_done_clr),
      .ovf(ovf), .wr_done(wr_done)
   );

   assign rd_tag  = head_ent[ENT_W-1:DATA_W];
   assign rd_data = head_ent[DATA_W-1:0];
   assign svc_irq = (cnt != '0);

   // R6: service request drops only after a read of the last entry
   a_r6_svc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_irq && !rd_pop) |=> svc_irq);

   // R8: an empty queue shows an all-zero tag
   a_r8_empty_tag: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_irq |-> (rd_tag == '0));
endmodule

// File: tb/test_i2c_rx_tagged_fifo.sv
module test_i2c_rx_tagged_fifo;
   localparam int DEPTH = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_byte = 0;
   logic [7:0] ev_data = '0;
   logic       ev_hit_a = 0, ev_hit_b = 0, ev_acked = 0, ev_tmo_nak = 0;
   logic       rd_pop = 0, wr_done_clr = 0, ovf_clr = 0;
   logic [7:0] rd_data;
   logic [6:0] rd_tag;
   logic       svc_irq, wr_done, ovf;

   int n_cmp = 0;
   int n_bad = 0;

   logic [14:0] m_q[$];
   logic        m_arm = 0, m_ovf = 0, m_done = 0;

   always #10 clk = ~clk;

   i2c_rx_tagged_fifo #(.DATA_W(8), .DEPTH(DEPTH)) i_i2c_rx_tagged_fifo (
      .clk(clk), .rst_n(rst_n),
      .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .ev_data(ev_data),
      .ev_hit_a(ev_hit_a), .ev_hit_b(ev_hit_b),
      .ev_acked(ev_acked), .ev_tmo_nak(ev_tmo_nak),
      .rd_pop(rd_pop), .rd_data(rd_data), .rd_tag(rd_tag),
      .svc_irq(svc_irq), .wr_done(wr_done), .wr_done_clr(wr_done_clr),
      .ovf(ovf), .ovf_clr(ovf_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [14:0] exp_head();
      return (m_q.size() > 0) ? m_q[0] : 15'h0;
   endfunction

   // ev: 0 idle, 1 START, 2 repeated START, 3 STOP, 4 byte; flg = {tmo, ack, hit_b, hit_a}
   task automatic cyc(input int ev, input logic [7:0] d, input logic [3:0] flg,
                      input logic p, input logic oc, input logic dc);
      logic [6:0]  tg;
      logic [14:0] ent;
      logic        pe, full, psh;
      ev_start = (ev == 1); ev_rstart = (ev == 2); ev_stop = (ev == 3); ev_byte = (ev == 4);
      ev_data = d;
      {ev_tmo_nak, ev_acked, ev_hit_b, ev_hit_a} = flg;
      rd_pop = p; ovf_clr = oc; wr_done_clr = dc;
      @(posedge clk);
      tg = 7'h0;
      if (ev == 4) tg = {2'b00, m_arm, flg};
      else if (ev == 2) tg = 7'h20;
      else if (ev == 3) tg = 7'h40;
      ent = {tg, (ev == 4) ? d : 8'h00};
      pe = p && (m_q.size() > 0);
      full = (m_q.size() == DEPTH);
      psh = (ev >= 2);
      if (pe) void'(m_q.pop_front());
      if (psh && (!full || pe)) m_q.push_back(ent);
      if (psh && full && !pe) m_ovf = 1'b1;
      else if (oc) m_ovf = 1'b0;
      if (ev == 3) m_done = 1'b1;
      else if (dc) m_done = 1'b0;
      if (ev == 4 || ev == 3) m_arm = 1'b0;
      else if (ev == 1 || ev == 2) m_arm = 1'b1;
      @(negedge clk);
      chk("R5 data", rd_data, exp_head() & 15'hff);
      chk("R5 tag", rd_tag, exp_head() >> 8);
      chk("R6 svc", svc_irq, m_q.size() > 0);
      chk("R7 ovf", ovf, m_ovf);
      chk("R9 done", wr_done, m_done);
      ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_byte = 0;
      rd_pop = 0; ovf_clr = 0; wr_done_clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1C2A5));
      repeat (3) @(negedge clk);
      chk("R8 reset tag", rd_tag, 0);
      chk("R8 reset data", rd_data, 0);
      chk("R6 reset svc", svc_irq, 0);
      chk("R7 reset ovf", ovf, 0);
      chk("R9 reset done", wr_done, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: first byte after START carries bit 4, the second does not
      cyc(1, 8'h00, 4'h0, 0, 0, 0);
      cyc(4, 8'h5A, 4'b0101, 0, 0, 0);
      chk("R1 R2 first tag", rd_tag, 7'h15);
      chk("R1 data", rd_data, 8'h5A);
      cyc(4, 8'h33, 4'b1001, 0, 0, 0);
      cyc(0, 8'h00, 4'h0, 1, 0, 0);
      chk("R2 second tag", rd_tag, 7'h09);
      chk("R5 second data", rd_data, 8'h33);
      cyc(0, 8'h00, 4'h0, 1, 0, 0);
      // R8: read on empty
      cyc(0, 8'h00, 4'h0, 1, 0, 0);
      chk("R8 empty tag", rd_tag, 0);
      cyc(4, 8'h77, 4'b0010, 0, 0, 0);
      chk("R8 no pointer move", rd_data, 8'h77);
      cyc(0, 8'h00, 4'h0, 1, 0, 0);
      // R3 / R2: repeated START marker, then the byte after it is first
      cyc(2, 8'hFF, 4'h0, 0, 0, 0);
      chk("R3 rstart tag", rd_tag, 7'h20);
      chk("R3 rstart data", rd_data, 0);
      cyc(4, 8'hC4, 4'b0110, 0, 0, 0);
      cyc(3, 8'hFF, 4'h0, 1, 0, 0);
      chk("R2 after rstart", rd_tag, 7'h16);
      chk("R9 stop sets done", wr_done, 1);
      cyc(0, 8'h00, 4'h0, 1, 0, 0);
      chk("R4 stop tag", rd_tag, 7'h40);
      chk("R4 stop data", rd_data, 0);
      cyc(3, 8'h00, 4'h0, 1, 0, 1);
      chk("R9 stop wins clear", wr_done, 1);
      cyc(0, 8'h00, 4'h0, 1, 0, 1);
      chk("R9 cleared", wr_done, 0);
      // R7: fill, then one more
      for (int i = 0; i < DEPTH; i++) cyc(4, 8'(8'h10 + i), 4'b0001, 0, 0, 0);
      cyc(4, 8'hEE, 4'b0001, 0, 0, 0);
      chk("R7 ovf set", ovf, 1);
      chk("R7 head kept", rd_data, 8'h10);
      cyc(4, 8'hAB, 4'b0001, 1, 0, 0);
      chk("R7 full push+pop head", rd_data, 8'h11);
      cyc(0, 8'h00, 4'h0, 0, 1, 0);
      chk("R7 ovf cleared", ovf, 0);
      for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 4'h0, 1, 0, 0);
      chk("R5 last out", svc_irq, 0);

      // random traffic with changing read pressure
      for (int ph = 0; ph < 12; ph++) begin
         int pp = (ph % 3 == 0) ? 10 : ((ph % 3 == 1) ? 50 : 85);
         for (int k = 0; k < 300; k++) begin
            int r = $urandom_range(0, 9);
            int ev = (r < 4) ? 4 : ((r == 4) ? 1 : ((r == 5) ? 2 : ((r == 6) ? 3 : 0)));
            cyc(ev, 8'($urandom), 4'($urandom),
                ($urandom_range(0, 99) < pp), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 9) == 0));
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule